// File: doc/BRIEF.md
# Clock Output Stop and Power-Down Gating

This block decides, on every cycle, the logical state of a bank of generated clock outputs: a PCI group of stoppable outputs, a small set of PCI outputs that may be kept free-running, and a group of CPU differential pairs with a true and a complement leg. Each output is reported as a 2-bit state code: held low, held high, running (following its source clock), or high-impedance. The analog drive strengths, slew and skew are left to the pad logic that consumes these codes.

The two free-running source clocks are oversampled by the block clock. The two active-low stop requests and the active-low power-down input are brought in through two-flop synchronisers. A stop lands on a defined edge of the source clock, so every output halts and resumes without a runt pulse. Per-output enables, per-output free-run selects and three high-impedance controls refine the result. The controls are a stop-to-high-Z bit and a power-down-to-high-Z bit for the CPU pairs, and a global force bit.

Top module: `clkgate_ctrl`

## Requirements
- R1: State codes are 2'b00 held low, 2'b01 held high, 2'b10 running, 2'b11 high-impedance. While `srst` is high every state output is 2'b00.
- R2: `pci_ref`, `cpu_ref`, `pci_stop_n`, `cpu_stop_n` and `pwrdn_n` each pass through two flops. A source edge is seen by comparing the second stage with one further delayed copy. State outputs are registered from the group halt flags, and the configuration inputs feed that state register directly. So a power-down input change applied between edges k and k+1 appears on the outputs after edge k+3.
- R3: While the PCI stop request is active, the PCI group halts on a high-to-low edge of the PCI source. From then on every PCI output reads 2'b00, and so does every free-running-capable PCI output whose `pcif_stoppable` bit is 1.
- R4: A free-running-capable PCI output with `pcif_stoppable` bit 0 keeps reading 2'b10 while the PCI stop request is active.
- R5: After the PCI stop request is withdrawn, the PCI group resumes on the next low-to-high edge of the PCI source, and the outputs return to 2'b10.
- R6: While the CPU stop request is active, the block counts two rising edges of the CPU source. On the next rising edge after that, the pairs marked stoppable (`cpu_stoppable` bit 1) park with true 2'b01 and complement 2'b00. With `stop_hiz` set, both legs read 2'b11 instead.
- R7: CPU pairs with `cpu_stoppable` bit 0 keep reading 2'b10 on both legs while the CPU stop request is active.
- R8: After the CPU stop request is withdrawn, parked CPU pairs resume on the next falling edge of the CPU source. The clear sample counter requires two fresh rising edges before the next stop.
- R9: While power-down is active, every PCI output reads 2'b00. Every CPU pair reads true 2'b01 and complement 2'b00, or 2'b11 on both legs when `pd_hiz` is set. This applies whatever the free-run bits are.
- R10: A PCI output whose enable bit is 0 reads 2'b00. A CPU pair whose enable bit is 0 is parked exactly as a stopped pair is, including the `stop_hiz` choice.
- R11: `force_hiz` set makes every output read 2'b11 on the next cycle.
- R12: Priority, highest first: `force_hiz`, power-down, enable bit 0, group halt, running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, oversamples the source clocks |
| srst | input | 1 | Synchronous active-high reset |
| cpu_ref | input | 1 | Free-running CPU source clock (sampled) |
| pci_ref | input | 1 | Free-running PCI source clock (sampled) |
| cpu_stop_n | input | 1 | Active-low CPU stop request, asynchronous |
| pci_stop_n | input | 1 | Active-low PCI stop request, asynchronous |
| pwrdn_n | input | 1 | Active-low power-down, asynchronous |
| pci_en | input | N_PCI | Enable per stoppable PCI output |
| pcif_en | input | N_PCIF | Enable per free-running-capable PCI output |
| pcif_stoppable | input | N_PCIF | 1 = output obeys PCI stop, 0 = free-running |
| cpu_en | input | N_CPU | Enable per CPU pair |
| cpu_stoppable | input | N_CPU | 1 = pair obeys CPU stop, 0 = free-running |
| stop_hiz | input | 1 | Stopped or disabled CPU pairs go high-impedance |
| pd_hiz | input | 1 | CPU pairs go high-impedance in power-down |
| force_hiz | input | 1 | All outputs high-impedance |
| pci_state | output | 2*N_PCI | State code per PCI output, output i at bits [2i+1:2i] |
| pcif_state | output | 2*N_PCIF | State code per free-running-capable PCI output |
| cpu_t_state | output | 2*N_CPU | State code per CPU true leg |
| cpu_c_state | output | 2*N_CPU | State code per CPU complement leg |

## Verification
The two source clocks run at unrelated periods while stop and power-down pulses are laid over them. This separates halts that land on the correct falling or rising source edge from halts taken on the wrong edge or one sample too early. Mixed free-run and stoppable selections in each group show that a stop touches only the outputs marked stoppable. Power-down is tried with and without `pd_hiz`, and stop with and without `stop_hiz`, so that the parked driven levels and high-impedance can be told apart. Stacking `force_hiz`, power-down and disables on top of one another exposes any error in the priority order.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
  typedef enum logic [1:0] {
    ST_LOW  = 2'b00,
    ST_HIGH = 2'b01,
    ST_RUN  = 2'b10,
    ST_HIZ  = 2'b11
  } out_state_e;
endpackage

// File: rtl/clkgate_sync2.sv
module clkgate_sync2 #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         srst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (srst) begin
      stage1 <= RST_VAL;
      stage2 <= RST_VAL;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/clkgate_stopgrp.sv
module clkgate_stopgrp #(
  parameter bit PARK_HIGH    = 1'b0,
  parameter int SAMPLE_EDGES = 2
) (
  input  logic clk,
  input  logic srst,
  input  logic ref_clk,
  input  logic stop_n,
  output logic halt
);
  localparam int CW = $clog2(SAMPLE_EDGES + 1);

  logic ref_s, ref_d, stop_s;
  logic rise, fall, req;
  logic halt_q;

  clkgate_sync2 #(.W(1), .RST_VAL(1'b0)) u_ref_sync (
    .clk(clk), .srst(srst), .d(ref_clk), .q(ref_s));
  clkgate_sync2 #(.W(1), .RST_VAL(1'b1)) u_stop_sync (
    .clk(clk), .srst(srst), .d(stop_n), .q(stop_s));

  always_ff @(posedge clk) begin
    if (srst) ref_d <= 1'b0;
    else      ref_d <= ref_s;
  end

  assign rise = ref_s & ~ref_d;
  assign fall = ~ref_s & ref_d;
  assign req  = ~stop_s;

  generate
    if (PARK_HIGH) begin : g_cpu
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (srst) begin
          cnt    <= '0;
          halt_q <= 1'b0;
        end else begin
          if (!req)
            cnt <= '0;
          else if (rise && !halt_q && cnt != CW'(SAMPLE_EDGES))
            cnt <= cnt + 1'b1;
          if (req && rise && cnt == CW'(SAMPLE_EDGES))
            halt_q <= 1'b1;
          else if (!req && fall)
            halt_q <= 1'b0;
        end
      end

      // R6
      cpu_two_sample_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(halt_q) |-> ($past(req) && $past(req, 2)));
      // R8
      cpu_release_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(halt_q) |-> !$past(req));
    end else begin : g_pci
      always_ff @(posedge clk) begin
        if (srst)
          halt_q <= 1'b0;
        else if (req && fall)
          halt_q <= 1'b1;
        else if (!req && rise)
          halt_q <= 1'b0;
      end

      // R3
      pci_halt_on_req_chk: assert property (@(posedge clk) disable iff (srst)
        $rose(halt_q) |-> $past(req));
      // R5
      pci_release_chk: assert property (@(posedge clk) disable iff (srst)
        $fell(halt_q) |-> !$past(req));
    end
  endgenerate

  assign halt = halt_q;
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int N_PCI  = 6,
  parameter int N_PCIF = 2,
  parameter int N_CPU  = 2,
  parameter int CPU_SAMPLE_EDGES = 2
) (
  input  logic                clk,
  input  logic                srst,
  input  logic                cpu_ref,
  input  logic                pci_ref,
  input  logic                cpu_stop_n,
  input  logic                pci_stop_n,
  input  logic                pwrdn_n,
  input  logic [N_PCI-1:0]    pci_en,
  input  logic [N_PCIF-1:0]   pcif_en,
  input  logic [N_PCIF-1:0]   pcif_stoppable,
  input  logic [N_CPU-1:0]    cpu_en,
  input  logic [N_CPU-1:0]    cpu_stoppable,
  input  logic                stop_hiz,
  input  logic                pd_hiz,
  input  logic                force_hiz,
  output logic [2*N_PCI-1:0]  pci_state,
  output logic [2*N_PCIF-1:0] pcif_state,
  output logic [2*N_CPU-1:0]  cpu_t_state,
  output logic [2*N_CPU-1:0]  cpu_c_state
);
  logic pd_n_s, pd_act;
  logic pci_halt, cpu_halt;

  clkgate_sync2 #(.W(1), .RST_VAL(1'b1)) u_pd_sync (
    .clk(clk), .srst(srst), .d(pwrdn_n), .q(pd_n_s));
  assign pd_act = ~pd_n_s;

  clkgate_stopgrp #(.PARK_HIGH(1'b0), .SAMPLE_EDGES(CPU_SAMPLE_EDGES)) u_pci_grp (
    .clk(clk), .srst(srst), .ref_clk(pci_ref), .stop_n(pci_stop_n), .halt(pci_halt));
  clkgate_stopgrp #(.PARK_HIGH(1'b1), .SAMPLE_EDGES(CPU_SAMPLE_EDGES)) u_cpu_grp (
    .clk(clk), .srst(srst), .ref_clk(cpu_ref), .stop_n(cpu_stop_n), .halt(cpu_halt));

  logic [1:0] pci_st  [N_PCI];
  logic [1:0] pcif_st [N_PCIF];
  logic [1:0] cpt_st  [N_CPU];
  logic [1:0] cpc_st  [N_CPU];

  generate
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci_out
      always_ff @(posedge clk) begin
        if (srst)                  pci_st[i] <= ST_LOW;
        else if (force_hiz)        pci_st[i] <= ST_HIZ;
        else if (pd_act)           pci_st[i] <= ST_LOW;
        else if (!pci_en[i])       pci_st[i] <= ST_LOW;
        else if (pci_halt)         pci_st[i] <= ST_LOW;
        else                       pci_st[i] <= ST_RUN;
      end
      assign pci_state[2*i +: 2] = pci_st[i];
    end

    for (genvar i = 0; i < N_PCIF; i++) begin : g_pcif_out
      always_ff @(posedge clk) begin
        if (srst)                                pcif_st[i] <= ST_LOW;
        else if (force_hiz)                      pcif_st[i] <= ST_HIZ;
        else if (pd_act)                         pcif_st[i] <= ST_LOW;
        else if (!pcif_en[i])                    pcif_st[i] <= ST_LOW;
        else if (pcif_stoppable[i] && pci_halt)  pcif_st[i] <= ST_LOW;
        else                                     pcif_st[i] <= ST_RUN;
      end
      assign pcif_state[2*i +: 2] = pcif_st[i];
    end

    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu_out
      logic parked;
      assign parked = !cpu_en[i] || (cpu_stoppable[i] && cpu_halt);
      always_ff @(posedge clk) begin
        if (srst) begin
          cpt_st[i] <= ST_LOW;  cpc_st[i] <= ST_LOW;
        end else if (force_hiz) begin
          cpt_st[i] <= ST_HIZ;  cpc_st[i] <= ST_HIZ;
        end else if (pd_act) begin
          cpt_st[i] <= pd_hiz ? ST_HIZ : ST_HIGH;
          cpc_st[i] <= pd_hiz ? ST_HIZ : ST_LOW;
        end else if (parked) begin
          cpt_st[i] <= stop_hiz ? ST_HIZ : ST_HIGH;
          cpc_st[i] <= stop_hiz ? ST_HIZ : ST_LOW;
        end else begin
          cpt_st[i] <= ST_RUN;  cpc_st[i] <= ST_RUN;
        end
      end
      assign cpu_t_state[2*i +: 2] = cpt_st[i];
      assign cpu_c_state[2*i +: 2] = cpc_st[i];
    end
  endgenerate

  // R11
  force_hiz_chk: assert property (@(posedge clk) disable iff (srst)
    force_hiz |=> (&pci_state && &pcif_state && &cpu_t_state && &cpu_c_state));

  // R9
  pd_pci_low_chk: assert property (@(posedge clk) disable iff (srst)
    (pd_act && !force_hiz) |=> (pci_state == '0 && pcif_state == '0));

  // R4
  pcif_free_chk: assert property (@(posedge clk) disable iff (srst)
    (!force_hiz && !pd_act && pcif_en[0] && !pcif_stoppable[0] && pci_halt)
      |=> (pcif_state[1:0] == ST_RUN));

  // R6
  cpu_park_chk: assert property (@(posedge clk) disable iff (srst)
    (!force_hiz && !pd_act && !stop_hiz && cpu_en[0] && cpu_stoppable[0] && cpu_halt)
      |=> (cpu_t_state[1:0] == ST_HIGH && cpu_c_state[1:0] == ST_LOW));
endmodule

// File: tb/test_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_clkgate_ctrl;
  localparam int NP = 6, NF = 2, NC = 2;

  logic clk = 1'b0;
  logic srst = 1'b1;
  logic cpu_ref = 1'b0, pci_ref = 1'b0;
  logic cpu_stop_n = 1'b1, pci_stop_n = 1'b1, pwrdn_n = 1'b1;
  logic [NP-1:0] pci_en = '1;
  logic [NF-1:0] pcif_en = '1;
  logic [NF-1:0] pcif_stoppable = 2'b01;
  logic [NC-1:0] cpu_en = '1;
  logic [NC-1:0] cpu_stoppable = 2'b01;
  logic stop_hiz = 1'b0, pd_hiz = 1'b0, force_hiz = 1'b0;
  logic [2*NP-1:0] pci_state;
  logic [2*NF-1:0] pcif_state;
  logic [2*NC-1:0] cpu_t_state, cpu_c_state;

  always #2.5 clk = ~clk;

  clkgate_ctrl #(.N_PCI(NP), .N_PCIF(NF), .N_CPU(NC)) i_clkgate_ctrl (
    .clk(clk), .srst(srst), .cpu_ref(cpu_ref), .pci_ref(pci_ref),
    .cpu_stop_n(cpu_stop_n), .pci_stop_n(pci_stop_n), .pwrdn_n(pwrdn_n),
    .pci_en(pci_en), .pcif_en(pcif_en), .pcif_stoppable(pcif_stoppable),
    .cpu_en(cpu_en), .cpu_stoppable(cpu_stoppable), .stop_hiz(stop_hiz),
    .pd_hiz(pd_hiz), .force_hiz(force_hiz), .pci_state(pci_state),
    .pcif_state(pcif_state), .cpu_t_state(cpu_t_state), .cpu_c_state(cpu_c_state));

  int checks = 0, errors = 0;
  string phase = "R1";

  // Histories of sampled inputs: bit0 one edge back, bit1 two, bit2 three.
  bit [2:0] h_pref, h_cref, h_pstop, h_cstop, h_pd;
  bit m_phalt, m_chalt;
  int m_ccnt;
  logic [2*NP-1:0] e_pci;
  logic [2*NF-1:0] e_pcif;
  logic [2*NC-1:0] e_ct, e_cc;
  int pdiv = 0, cdiv = 0;

  task automatic model_step();
    bit pd_on, prise, pfall, preq, crise, cfall, creq, new_ch;
    if (srst) begin
      h_pref = '0; h_cref = '0; h_pstop = '1; h_cstop = '1; h_pd = '1;
      m_phalt = 0; m_chalt = 0; m_ccnt = 0;
      e_pci = '0; e_pcif = '0; e_ct = '0; e_cc = '0;
      return;
    end
    pd_on = !h_pd[1];
    for (int i = 0; i < NP; i++)
      e_pci[2*i +: 2] = force_hiz ? 2'b11 : (pd_on || !pci_en[i] || m_phalt) ? 2'b00 : 2'b10;
    for (int i = 0; i < NF; i++)
      e_pcif[2*i +: 2] = force_hiz ? 2'b11 :
        (pd_on || !pcif_en[i] || (pcif_stoppable[i] && m_phalt)) ? 2'b00 : 2'b10;
    for (int i = 0; i < NC; i++) begin
      if (force_hiz) begin e_ct[2*i +: 2] = 2'b11; e_cc[2*i +: 2] = 2'b11; end
      else if (pd_on) begin
        e_ct[2*i +: 2] = pd_hiz ? 2'b11 : 2'b01; e_cc[2*i +: 2] = pd_hiz ? 2'b11 : 2'b00;
      end else if (!cpu_en[i] || (cpu_stoppable[i] && m_chalt)) begin
        e_ct[2*i +: 2] = stop_hiz ? 2'b11 : 2'b01; e_cc[2*i +: 2] = stop_hiz ? 2'b11 : 2'b00;
      end else begin e_ct[2*i +: 2] = 2'b10; e_cc[2*i +: 2] = 2'b10; end
    end
    prise = h_pref[1] && !h_pref[2]; pfall = !h_pref[1] && h_pref[2]; preq = !h_pstop[1];
    if (preq && pfall) m_phalt = 1; else if (!preq && prise) m_phalt = 0;
    crise = h_cref[1] && !h_cref[2]; cfall = !h_cref[1] && h_cref[2]; creq = !h_cstop[1];
    new_ch = m_chalt;
    if (creq && crise && m_ccnt == 2) new_ch = 1; else if (!creq && cfall) new_ch = 0;
    if (!creq) m_ccnt = 0;
    else if (crise && !m_chalt && m_ccnt != 2) m_ccnt = m_ccnt + 1;
    m_chalt = new_ch;
    h_pref = {h_pref[1:0], pci_ref};   h_cref = {h_cref[1:0], cpu_ref};
    h_pstop = {h_pstop[1:0], pci_stop_n}; h_cstop = {h_cstop[1:0], cpu_stop_n};
    h_pd = {h_pd[1:0], pwrdn_n};
  endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
    model_step();
    chk({phase, " cycle"}, {pci_state, pcif_state}, {e_pci, e_pcif});
    chk({phase, " cycle cpu"}, {8'h0, cpu_t_state, cpu_c_state}, {8'h0, e_ct, e_cc});
    pdiv++; if (pdiv == 5) begin pdiv = 0; pci_ref = ~pci_ref; end
    cdiv++; if (cdiv == 3) begin cdiv = 0; cpu_ref = ~cpu_ref; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(200000 * 5.0);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    run(4);
    chk("R1 reset state", {pci_state, pcif_state}, 16'h0);
    chk("R1 reset state cpu", {8'h0, cpu_t_state, cpu_c_state}, 16'h0);
    srst = 1'b0;
    phase = "R1,R12 run";
    run(40);
    chk("R1 running", {pci_state, pcif_state}, 16'hAAAA);

    phase = "R3,R4 pci stop";
    pci_stop_n = 1'b0;
    run(80);
    chk("R3 pci halted", {4'h0, pci_state}, 16'h0000);
    chk("R4 free pcif runs", {12'h0, pcif_state}, 16'h0008);
    phase = "R5 pci release";
    pci_stop_n = 1'b1;
    run(60);
    chk("R5 pci resumed", {pci_state, pcif_state}, 16'hAAAA);

    phase = "R6,R7 cpu stop";
    cpu_stop_n = 1'b0;
    run(80);
    chk("R6 cpu parked", {8'h0, cpu_t_state, cpu_c_state}, 16'h0098);
    phase = "R8 cpu release";
    cpu_stop_n = 1'b1;
    run(60);
    chk("R8 cpu resumed", {8'h0, cpu_t_state, cpu_c_state}, 16'h00AA);
    phase = "R6 cpu stop hiz";
    stop_hiz = 1'b1;
    cpu_stop_n = 1'b0;
    run(80);
    chk("R6 cpu stop hiz", {8'h0, cpu_t_state, cpu_c_state}, 16'h00BB);
    cpu_stop_n = 1'b1;
    phase = "R8 cpu release";
    run(60);
    stop_hiz = 1'b0;
    run(4);

    phase = "R2,R9 power-down";
    pwrdn_n = 1'b0;
    tick(); tick();
    chk("R2 pd not yet seen", {pci_state, pcif_state}, 16'hAAAA);
    tick();
    chk("R2 pd seen third edge", {pci_state, pcif_state}, 16'h0000);
    run(10);
    chk("R9 pd cpu driven", {8'h0, cpu_t_state, cpu_c_state}, 16'h0050);
    pd_hiz = 1'b1;
    tick();
    chk("R9 pd cpu hiz", {8'h0, cpu_t_state, cpu_c_state}, 16'h00FF);
    force_hiz = 1'b1;
    phase = "R11,R12 force over pd";
    tick();
    chk("R12 force beats pd", {pci_state, pcif_state}, 16'hFFFF);
    force_hiz = 1'b0;
    pd_hiz = 1'b0;
    pwrdn_n = 1'b1;
    phase = "R9 pd exit";
    run(40);

    phase = "R10 disables";
    pci_en = 6'b111011;
    cpu_en = 2'b01;
    run(20);
    chk("R10 pci disabled", {4'h0, pci_state}, 16'h0A8A);
    chk("R10 cpu disabled", {8'h0, cpu_t_state, cpu_c_state}, 16'h0062);
    phase = "R12 disable with stop";
    pci_stop_n = 1'b0;
    cpu_stop_n = 1'b0;
    pcif_stoppable = 2'b11;
    run(80);
    chk("R12 stop plus disable", {pci_state, pcif_state}, 16'h0000);
    chk("R12 cpu stop plus disable", {8'h0, cpu_t_state, cpu_c_state}, 16'h0050);

    phase = "R11 force";
    force_hiz = 1'b1;
    tick();
    chk("R11 all hiz", {pci_state, pcif_state}, 16'hFFFF);
    chk("R11 all hiz cpu", {8'h0, cpu_t_state, cpu_c_state}, 16'h00FF);
    force_hiz = 1'b0;
    pci_stop_n = 1'b1;
    cpu_stop_n = 1'b1;
    phase = "R5,R8 final release";
    run(60);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule